// File: doc/BRIEF.md
# Configuration Port Unlock and Banked Register File

This block is the chip-side decoder behind a two-byte legacy I/O configuration window. Byte offset 0 is the index port and byte offset 1 is the data port. Host software writes a register number to the index port and then reads or writes that register through the data port. Configuration access starts closed. It opens only after a key byte sequence has been written to the index port. Once open, a small set of global registers is visible, together with a per-device bank of resource registers.

Two key styles are supported, and a parameter selects one of them. The four-byte style has a final byte that depends on the base-address strap: 0x55 at base 0x2E and 0xAA at base 0x4E. This style closes when 0x02 is written into global register 0x02. The two-byte style opens on a repeated 0x87 and closes when 0xAA is written to the index port. Global register 0x07 selects the logical device. Every index from 0x30 upward addresses that device's private bank, which holds an activate register, two 16-bit I/O bases, an IRQ select and a DMA select. The bank storage is a plain synchronous RAM. Read data appears two clock cycles after the read strobe.

Top module: `cfgsp_port_ctrl`

## Requirements
- R1: After reset, `cfg_open` is 0, `rd_valid` is 0, `rd_data` is 0x00, the device select (index 0x07) holds 0 and the current index holds 0.
- R2: While closed, a data-port read returns 0xFF and an index-port read returns 0xFF. A data-port write changes no register: a device select written before closing reads back unchanged after reopening.
- R3: In the four-byte style, the unlock sequence on the index port is 0x87, 0x01, 0x55 and then a final byte. That final byte is 0x55 when `base_hi` is 0 (base 0x2E) and 0xAA when `base_hi` is 1 (base 0x4E). The other final byte leaves the port closed.
- R4: A closed-state index byte that breaks the sequence returns the matcher to its first step. If that byte is 0x87, the matcher instead continues from the step after the first, so 0x87 0x87 0x01 0x55 <final> opens.
- R5: In the four-byte style, a data write of 0x02 while the index is 0x02 closes the port. Any other value written to index 0x02 leaves it open.
- R6: In the two-byte style, the port opens after two consecutive 0x87 index writes, and an index write of 0xAA while open closes it.
- R7: Index 0x20 reads the ID high byte and index 0x21 reads the ID low byte. Index 0x22 reads the revision byte in the four-byte style and 0xFF in the two-byte style. Writes to these indices are ignored.
- R8: Index 0x07 is a read/write device select. Banked registers of different devices are independent.
- R9: In each device bank, indices 0x30 (activate), 0x60/0x61 (primary base, high byte first), 0x62/0x63 (secondary base, high byte first), 0x70 (IRQ) and 0x74 (DMA) are read/write. Any other index of 0x30 or above reads 0xFF, and writes to it are ignored.
- R10: With a device select of NUM_LDN or above, banked reads return 0xFF and banked writes are ignored. Such a write does not alias into device (select mod NUM_LDN).
- R11: `rd_valid` pulses for one cycle, two clock cycles after the read strobe. An index-port read while open returns the current index.
- R12: Global indices below 0x30 other than 0x02, 0x07 and 0x20 to 0x22 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_hi | input | 1 | Base strap: 0 selects base 0x2E, 1 selects base 0x4E |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 1 | Port offset: 0 index, 1 data |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | Read byte valid, two cycles after `bus_rd` |
| cfg_open | output | 1 | Configuration access open |

## Verification
The hardest states to reach are the overlapping key restart and an out-of-range device select. For the restart, the stimulus feeds a sequence broken by a stray byte, and then a repeated 0x87 that has to be taken as the start of a fresh match rather than discarded. For the select case, a distinct value is written into device 4's activate register, the select is moved to 20 (which shares its low four bits with 4), and a write is attempted there. Reading device 4 back shows whether the write was dropped or aliased. Writes made while closed are proven ignored by closing with a known device select, writing over the data port, reopening and reading the select.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  typedef enum logic [0:0] {
    KEY_FOUR_BYTE = 1'b0,
    KEY_DOUBLE    = 1'b1
  } key_style_e;

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] IDX_LDN_SEL = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BANKED  = 8'h30;

  localparam int SLOT_W = 3;

  // Bank slot map: {hit, slot}
  function automatic logic [SLOT_W:0] bank_slot(input logic [7:0] idx);
    logic [SLOT_W:0] r;
    case (idx)
      8'h30:   r = {1'b1, 3'd0};
      8'h60:   r = {1'b1, 3'd1};
      8'h61:   r = {1'b1, 3'd2};
      8'h62:   r = {1'b1, 3'd3};
      8'h63:   r = {1'b1, 3'd4};
      8'h70:   r = {1'b1, 3'd5};
      8'h74:   r = {1'b1, 3'd6};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfgsp_key_match.sv
module cfgsp_key_match
  import cfgsp_pkg::*;
#(
  parameter key_style_e KEY_STYLE = KEY_FOUR_BYTE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       base_hi,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] cur_index,
  output logic       open_q
);

  localparam int KEY_LEN = (KEY_STYLE == KEY_FOUR_BYTE) ? 4 : 2;
  localparam int STEP_W  = 2;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic [7:0]        tail_byte;
  logic [7:0]        want_byte;
  logic              exit_hit;

  assign tail_byte = base_hi ? 8'hAA : 8'h55;

  always_comb begin
    case (step_q)
      2'd0:    want_byte = 8'h87;
      2'd1:    want_byte = (KEY_STYLE == KEY_FOUR_BYTE) ? 8'h01 : 8'h87;
      2'd2:    want_byte = 8'h55;
      default: want_byte = tail_byte;
    endcase
  end

  generate
    if (KEY_STYLE == KEY_FOUR_BYTE) begin : g_exit_reg
      assign exit_hit = data_wr && (cur_index == IDX_EXIT) && (wdata == 8'h02);
    end else begin : g_exit_idx
      assign exit_hit = idx_wr && (wdata == 8'hAA);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      step_q <= '0;
    end else if (open_q) begin
      if (exit_hit) begin
        open_q <= 1'b0;
        step_q <= '0;
      end
    end else if (idx_wr) begin
      if (wdata == want_byte) begin
        if (step_q == LAST_STEP) begin
          open_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else if (wdata == 8'h87) begin
        step_q <= STEP_W'(1);
      end else begin
        step_q <= '0;
      end
    end
  end

  AST_OPEN_FROM_INDEX: assert property (@(posedge clk) disable iff (rst)
    $rose(open_q) |-> $past(idx_wr)) else $error("open without index write"); // R3
  AST_CLOSE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(open_q) |-> $past(idx_wr || data_wr)) else $error("close without write"); // R5
  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    step_q <= LAST_STEP) else $error("step out of range"); // R4
  AST_STEP_IDLE_OPEN: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (step_q == '0)) else $error("step moved while open"); // R4

endmodule

// File: rtl/cfgsp_bank_ram.sv
module cfgsp_bank_ram #(
  parameter int DW     = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DW-1:0]     wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DW-1:0]     rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cfgsp_port_ctrl.sv
module cfgsp_port_ctrl
  import cfgsp_pkg::*;
#(
  parameter key_style_e KEY_STYLE = KEY_FOUR_BYTE,
  parameter int         NUM_LDN   = 16,
  parameter logic [7:0] ID_HI     = 8'hA5,
  parameter logic [7:0] ID_LO     = 8'h3C,
  parameter logic [7:0] REV_ID    = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       base_hi,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       cfg_open
);

  localparam int LDN_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam int ADDR_W = LDN_W + SLOT_W;
  localparam logic [7:0] REV_SEEN = (KEY_STYLE == KEY_FOUR_BYTE) ? REV_ID : 8'hFF;

  logic             idx_wr, data_wr, data_rd;
  logic [7:0]       index_q, ldn_q;
  logic [SLOT_W:0]  slot_info;
  logic             slot_hit, is_banked, ldn_ok;
  logic [ADDR_W-1:0] ram_addr;
  logic             ram_we, ram_re;
  logic [7:0]       ram_q;
  logic [7:0]       const_val;
  logic             s1_valid, s1_use_ram;
  logic [7:0]       s1_const;

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr && bus_addr;
  assign data_rd = bus_rd && bus_addr;

  cfgsp_key_match #(.KEY_STYLE(KEY_STYLE)) u_key (
    .clk       (clk),
    .rst       (rst),
    .base_hi   (base_hi),
    .idx_wr    (idx_wr),
    .data_wr   (data_wr),
    .wdata     (bus_wdata),
    .cur_index (index_q),
    .open_q    (cfg_open)
  );

  // Index and device select
  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else if (cfg_open) begin
      if (idx_wr) index_q <= bus_wdata;
      if (data_wr && index_q == IDX_LDN_SEL) ldn_q <= bus_wdata;
    end
  end

  // Bank decode
  assign slot_info = bank_slot(index_q);
  assign slot_hit  = slot_info[SLOT_W];
  assign is_banked = index_q >= IDX_BANKED;
  assign ldn_ok    = {24'd0, ldn_q} < NUM_LDN;
  assign ram_addr  = {ldn_q[LDN_W-1:0], slot_info[SLOT_W-1:0]};
  assign ram_we    = data_wr && cfg_open && is_banked && slot_hit && ldn_ok;
  assign ram_re    = data_rd && cfg_open && is_banked && slot_hit && ldn_ok;

  cfgsp_bank_ram #(.DW(8), .ADDR_W(ADDR_W)) u_bank (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_addr),
    .wdata (bus_wdata),
    .re    (ram_re),
    .raddr (ram_addr),
    .rdata (ram_q)
  );

  // Non-RAM read value
  always_comb begin
    const_val = 8'hFF;
    if (!bus_addr) begin
      const_val = cfg_open ? index_q : 8'hFF;
    end else if (cfg_open) begin
      case (index_q)
        IDX_LDN_SEL: const_val = ldn_q;
        IDX_ID_HI:   const_val = ID_HI;
        IDX_ID_LO:   const_val = ID_LO;
        IDX_REV:     const_val = REV_SEEN;
        default:     const_val = 8'hFF;
      endcase
    end
  end

  // Two-stage read pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_use_ram <= 1'b0;
      s1_const   <= 8'hFF;
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
    end else begin
      s1_valid   <= bus_rd;
      s1_use_ram <= ram_re;
      s1_const   <= const_val;
      rd_valid   <= s1_valid;
      if (s1_valid) rd_data <= s1_use_ram ? ram_q : s1_const;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_rd, 2)) else $error("rd_valid without strobe"); // R11
  AST_CLOSED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !cfg_open) |-> ##2 (rd_data == 8'hFF)) else $error("closed read not FF"); // R2
  AST_CLOSED_LDN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_open |=> $stable(ldn_q)) else $error("select changed while closed"); // R2
  AST_RAM_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (cfg_open && ldn_q < 8'(NUM_LDN))) else $error("bank write out of range"); // R10

endmodule

// File: tb/cfgsp_port_ctrl_bench.sv
module cfgsp_port_ctrl_bench;
  import cfgsp_pkg::*;

  localparam logic [7:0] E_ID_HI = 8'hA5;
  localparam logic [7:0] E_ID_LO = 8'h3C;
  localparam logic [7:0] E_REV   = 8'h07;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       base_hi = 1'b0;
  logic       wr_a = 0, rd_a = 0, ad_a = 0, wr_b = 0, rd_b = 0, ad_b = 0;
  logic [7:0] wd_a = 0, wd_b = 0;
  logic [7:0] rdata_a, rdata_b;
  logic       rv_a, rv_b, open_a, open_b;

  cfgsp_port_ctrl #(.KEY_STYLE(KEY_FOUR_BYTE)) u_cfgsp_port_ctrl (
    .clk(clk), .rst(rst), .base_hi(base_hi), .bus_wr(wr_a), .bus_rd(rd_a),
    .bus_addr(ad_a), .bus_wdata(wd_a), .rd_data(rdata_a), .rd_valid(rv_a), .cfg_open(open_a));

  cfgsp_port_ctrl #(.KEY_STYLE(KEY_DOUBLE)) u_cfgsp_port_ctrl_b (
    .clk(clk), .rst(rst), .base_hi(1'b0), .bus_wr(wr_b), .bus_rd(rd_b),
    .bus_addr(ad_b), .bus_wdata(wd_b), .rd_data(rdata_b), .rd_valid(rv_b), .cfg_open(open_b));

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_a[$];
  logic [7:0] exp_b[$];
  string      tag_a[$];
  string      tag_b[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit i, input bit a, input logic [7:0] d);
    @(negedge clk);
    if (i) begin wr_b = 1; ad_b = a; wd_b = d; end
    else   begin wr_a = 1; ad_a = a; wd_a = d; end
    @(negedge clk);
    wr_a = 0; wr_b = 0;
  endtask

  task automatic rd(input bit i, input bit a, input logic [7:0] e, input string tag);
    @(negedge clk);
    if (i) begin exp_b.push_back(e); tag_b.push_back(tag); rd_b = 1; ad_b = a; end
    else   begin exp_a.push_back(e); tag_a.push_back(tag); rd_a = 1; ad_a = a; end
    @(negedge clk);
    rd_a = 0; rd_b = 0;
  endtask

  task automatic reg_wr(input bit i, input logic [7:0] idx, input logic [7:0] d);
    wr(i, 0, idx);
    wr(i, 1, d);
  endtask

  task automatic reg_rd(input bit i, input logic [7:0] idx, input logic [7:0] e, input string tag);
    wr(i, 0, idx);
    rd(i, 1, e, tag);
  endtask

  task automatic keys4(input logic [7:0] k3);
    wr(0, 0, 8'h87); wr(0, 0, 8'h01); wr(0, 0, 8'h55); wr(0, 0, k3);
  endtask

  // Monitor: pop and compare scoreboard entries
  always @(negedge clk) begin
    if (!rst && rv_a) begin
      if (exp_a.size() == 0) chk("R11 unexpected rd_valid A", rdata_a, 8'hXX);
      else chk(tag_a.pop_front(), rdata_a, exp_a.pop_front());
    end
    if (!rst && rv_b) begin
      if (exp_b.size() == 0) chk("R11 unexpected rd_valid B", rdata_b, 8'hXX);
      else chk(tag_b.pop_front(), rdata_b, exp_b.pop_front());
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_open A", {7'd0, open_a}, 8'h00);
    chk("R1 cfg_open B", {7'd0, open_b}, 8'h00);
    chk("R1 rd_valid", {7'd0, rv_a}, 8'h00);
    chk("R1 rd_data", rdata_a, 8'h00);
    // R2 closed reads
    rd(0, 1, 8'hFF, "R2 closed data read");
    rd(0, 0, 8'hFF, "R2 closed index read");
    // R3 wrong final byte at base 0x2E
    keys4(8'hAA);
    chk("R3 wrong final byte stays closed", {7'd0, open_a}, 8'h00);
    // R4 broken then restart on repeated 0x87
    wr(0, 0, 8'h87); wr(0, 0, 8'h01); wr(0, 0, 8'h33); wr(0, 0, 8'h55);
    chk("R4 broken sequence closed", {7'd0, open_a}, 8'h00);
    wr(0, 0, 8'h87);
    keys4(8'h55);
    chk("R4 restart from 0x87 opens", {7'd0, open_a}, 8'h01);
    // R1 reset values of index and select
    rd(0, 0, 8'h00, "R1 index after reset");
    reg_rd(0, 8'h07, 8'h00, "R1 select after reset");
    // R11 index read and latency
    rd(0, 0, 8'h07, "R11 index port readback");
    @(negedge clk);
    exp_a.push_back(8'h00); tag_a.push_back("R11 latency data"); rd_a = 1; ad_a = 1;
    @(negedge clk); rd_a = 0;
    chk("R11 no valid after 1 cycle", {7'd0, rv_a}, 8'h00);
    @(negedge clk);
    chk("R11 valid after 2 cycles", {7'd0, rv_a}, 8'h01);
    @(negedge clk);
    chk("R11 valid is one pulse", {7'd0, rv_a}, 8'h00);
    // R2 closed write ignored: set select 3, close, write, reopen
    reg_wr(0, 8'h07, 8'h03);
    reg_wr(0, 8'h02, 8'h02);
    chk("R5 exit closes", {7'd0, open_a}, 8'h00);
    wr(0, 0, 8'h07);
    wr(0, 1, 8'h09);
    keys4(8'h55);
    wr(0, 0, 8'h07);
    rd(0, 1, 8'h03, "R2 closed write ignored");
    // R7 identification
    reg_rd(0, 8'h20, E_ID_HI, "R7 id high");
    reg_rd(0, 8'h21, E_ID_LO, "R7 id low");
    reg_rd(0, 8'h22, E_REV, "R7 revision four-byte style");
    reg_wr(0, 8'h20, 8'h00);
    reg_rd(0, 8'h20, E_ID_HI, "R7 id write ignored");
    // R12 unimplemented global
    reg_rd(0, 8'h10, 8'hFF, "R12 unmapped global");
    // R8 R9 banks
    reg_wr(0, 8'h07, 8'h02);
    reg_wr(0, 8'h30, 8'h01); reg_wr(0, 8'h60, 8'h12); reg_wr(0, 8'h61, 8'h34);
    reg_wr(0, 8'h62, 8'h56); reg_wr(0, 8'h63, 8'h78);
    reg_wr(0, 8'h70, 8'h05); reg_wr(0, 8'h74, 8'h03);
    reg_wr(0, 8'h07, 8'h05);
    reg_wr(0, 8'h30, 8'h00); reg_wr(0, 8'h60, 8'hAB);
    reg_wr(0, 8'h40, 8'h77);
    reg_rd(0, 8'h40, 8'hFF, "R9 unmapped banked index");
    reg_rd(0, 8'h30, 8'h00, "R8 device 5 activate");
    reg_rd(0, 8'h60, 8'hAB, "R8 device 5 base high");
    reg_rd(0, 8'h07, 8'h05, "R8 select readback");
    reg_wr(0, 8'h07, 8'h02);
    reg_rd(0, 8'h30, 8'h01, "R9 activate");
    reg_rd(0, 8'h60, 8'h12, "R9 base0 high");
    reg_rd(0, 8'h61, 8'h34, "R9 base0 low");
    reg_rd(0, 8'h62, 8'h56, "R9 base1 high");
    reg_rd(0, 8'h63, 8'h78, "R9 base1 low");
    reg_rd(0, 8'h70, 8'h05, "R9 irq");
    reg_rd(0, 8'h74, 8'h03, "R9 dma");
    // R10 out-of-range select
    reg_wr(0, 8'h07, 8'h04);
    reg_wr(0, 8'h30, 8'h11);
    reg_wr(0, 8'h07, 8'h14);
    reg_wr(0, 8'h30, 8'hEE);
    reg_rd(0, 8'h30, 8'hFF, "R10 out-of-range read");
    reg_wr(0, 8'h07, 8'h04);
    reg_rd(0, 8'h30, 8'h11, "R10 no alias into device 4");
    // R5 exit values
    reg_wr(0, 8'h02, 8'h01);
    chk("R5 other value stays open", {7'd0, open_a}, 8'h01);
    wr(0, 1, 8'h02);
    chk("R5 0x02 closes", {7'd0, open_a}, 8'h00);
    rd(0, 1, 8'hFF, "R2 read after close");
    // R3 base 0x4E
    base_hi = 1'b1;
    keys4(8'h55);
    chk("R3 base 4E rejects 0x55", {7'd0, open_a}, 8'h00);
    keys4(8'hAA);
    chk("R3 base 4E opens on 0xAA", {7'd0, open_a}, 8'h01);
    reg_wr(0, 8'h02, 8'h02);
    // R6 two-byte style
    wr(1, 0, 8'h87); wr(1, 0, 8'h01);
    chk("R6 broken double key closed", {7'd0, open_b}, 8'h00);
    wr(1, 0, 8'h87);
    chk("R6 single 0x87 closed", {7'd0, open_b}, 8'h00);
    wr(1, 0, 8'h87);
    chk("R6 double 0x87 opens", {7'd0, open_b}, 8'h01);
    reg_rd(1, 8'h20, E_ID_HI, "R7 id high two-byte style");
    reg_rd(1, 8'h22, 8'hFF, "R7 no revision in two-byte style");
    reg_wr(1, 8'h02, 8'h02);
    chk("R6 register exit not used", {7'd0, open_b}, 8'h01);
    wr(1, 0, 8'hAA);
    chk("R6 0xAA index closes", {7'd0, open_b}, 8'h00);
    rd(1, 1, 8'hFF, "R6 closed read");
    repeat (5) @(negedge clk);
    chk("R11 scoreboard A drained", 8'(exp_a.size()), 8'h00);
    chk("R11 scoreboard B drained", 8'(exp_b.size()), 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule